// File: doc/BRIEF.md
# Bit-Split Match State Tile

This block is one table-driven finite automaton of a multi-pattern string matcher that looks at only a two-bit slice of every incoming byte. A bank of such tiles, each watching a different slice, runs in parallel on the same byte stream. A downstream AND of their partial match vectors yields the full match for a rule group. The tile holds a state table. Every state entry has one next-state pointer for each of the four slice values, plus a partial match vector with one bit per pattern. A set bit means that pattern's last character agrees with this slice.

Tables are built offline and written through a configuration port while scanning is disabled. During a scan, every valid byte moves the tile along exactly one edge: the slice value picks a pointer in the current entry. The tile registers the new state together with that state's partial match vector. The stream is read once, with no backtracking.

Top module: `bsm_tile`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `state_o` to 0, sets `pmv_o` to 0 and clears every table entry, so all pointers and all stored vectors are 0.
- R2: The slice value k is `sym_byte[SLICE_LO+1:SLICE_LO]` (bits [1:0] by default). Byte bits outside the slice have no effect on the transition.
- R3: On a clock edge with `scan_en` and `sym_valid` both high, `state_o` becomes pointer k of the current state's entry. Pointer k is stored from `cfg_next[8k+7:8k]`. There is one transition per valid byte.
- R4: After each transition, `pmv_o` equals the stored vector of the state just entered. It updates on the same edge as `state_o`.
- R5: Whenever the state entered is 0 (the start state), `pmv_o` reads 0, whatever vector is stored for entry 0.
- R6: While `sym_valid` is low, `state_o` and `pmv_o` keep their values.
- R7: A configuration write (`cfg_we` high) at an edge where `scan_en` is high is ignored, and the table keeps its contents.
- R8: While `scan_en` is low, valid bytes cause no transition, and `state_o` and `pmv_o` hold.
- R9: An entry never written since reset sends every slice value back to state 0 and shows a vector of 0.
- R10: A write with `scan_en` low stores `{cfg_pmv, cfg_next}` at `cfg_addr`. Later transitions use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Scan enable; the table is writable only while this is low |
| sym_valid | input | 1 | The byte on `sym_byte` is valid this cycle |
| sym_byte | input | SYM_W (8) | Input character |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | ST_W (8) | State entry to write |
| cfg_next | input | 4*ST_W (32) | Four next-state pointers, pointer k in bits [8k+7:8k] |
| cfg_pmv | input | PM_W (16) | Partial match vector for the entry |
| state_o | output | ST_W (8) | Current state |
| pmv_o | output | PM_W (16) | Partial match vector of the current state |

## Verification
The assertions assume that reset is applied at the start, so that state, vector and table all begin from known zeros. They also assume the table changes only on edges with `scan_en` low. The hold and step properties take the combined advance condition as their trigger and make no claim about unknown input values. The stimulus drives every input at the falling edge, keeps every input at a defined level from time zero, and issues writes both with scanning disabled and, on purpose, with it enabled. A sweep of all 256 byte values walks a computed sixteen-state table that includes pointers into unwritten entries.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
   // number of edges leaving a state for a slice of width w
   function automatic int fan_of(input int w);
      return 1 << w;
   endfunction
endpackage

// File: rtl/bsm_slice.sv
module bsm_slice #(
   parameter int SYM_W    = 8,
   parameter int SLICE_W  = 2,
   parameter int SLICE_LO = 0
) (
   input  logic [SYM_W-1:0]   sym,
   output logic [SLICE_W-1:0] sel
);
   generate
      if (SLICE_W == SYM_W) begin : g_full
         assign sel = sym;
      end else begin : g_part
         logic slice_unused;
         assign slice_unused = ^sym;
         assign sel = sym[SLICE_LO +: SLICE_W];
      end
   endgenerate
endmodule

// File: rtl/bsm_table.sv
module bsm_table #(
   parameter int ST_W    = 8,
   parameter int PM_W    = 16,
   parameter int SLICE_W = 2
) (
   input  logic                                     clk,
   input  logic                                     rst,
   input  logic                                     scan_en,
   input  logic                                     wr_req,
   input  logic [ST_W-1:0]                          wr_addr,
   input  logic [bsm_pkg::fan_of(SLICE_W)*ST_W-1:0] wr_ptrs,
   input  logic [PM_W-1:0]                          wr_pmv,
   input  logic [ST_W-1:0]                          rd_state,
   input  logic [SLICE_W-1:0]                       rd_sel,
   output logic [ST_W-1:0]                          nxt_ptr,
   output logic [PM_W-1:0]                          nxt_pmv
);
   localparam int FAN   = bsm_pkg::fan_of(SLICE_W);
   localparam int PTR_W = FAN * ST_W;
   localparam int ENT_W = PTR_W + PM_W;
   localparam int DEPTH = 1 << ST_W;

   logic [DEPTH-1:0][ENT_W-1:0] mem_q;
   logic [ENT_W-1:0]            cur_ent;
   logic [ENT_W-1:0]            tgt_ent;
   logic [ST_W-1:0]             edge_a [FAN];

   // entry layout: {vector, pointer FAN-1 .. pointer 0}
   always_ff @(posedge clk) begin
      if (rst)
         mem_q <= '0;
      else if (wr_req && !scan_en)
         mem_q[wr_addr] <= {wr_pmv, wr_ptrs};
   end

   assign cur_ent = mem_q[rd_state];

   generate
      for (genvar g = 0; g < FAN; g++) begin : g_edge
         assign edge_a[g] = cur_ent[g*ST_W +: ST_W];
      end
   endgenerate

   assign nxt_ptr = edge_a[rd_sel];
   assign tgt_ent = mem_q[nxt_ptr];
   assign nxt_pmv = tgt_ent[ENT_W-1 -: PM_W];

   // R7: no table change across an edge that saw scan_en high
   p_locked_r7: assert property (@(posedge clk) disable iff (rst)
      scan_en |=> $stable(mem_q))
      else $error("table changed while scanning");
endmodule

// File: rtl/bsm_step.sv
module bsm_step #(
   parameter int ST_W = 8,
   parameter int PM_W = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            adv,
   input  logic [ST_W-1:0] nxt_ptr,
   input  logic [PM_W-1:0] nxt_pmv,
   output logic [ST_W-1:0] state_q,
   output logic [PM_W-1:0] pmv_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= '0;
         pmv_q   <= '0;
      end else if (adv) begin
         state_q <= nxt_ptr;
         pmv_q   <= (nxt_ptr == '0) ? '0 : nxt_pmv;
      end
   end

   // R6 and R8: no advance means nothing moves
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !adv |=> ($stable(state_q) && $stable(pmv_q)))
      else $error("state moved without advance");

   p_step_r3: assert property (@(posedge clk) disable iff (rst)
      adv |=> (state_q == $past(nxt_ptr)))
      else $error("state is not the selected pointer");

   p_zero_pmv_r5: assert property (@(posedge clk) disable iff (rst)
      (state_q == '0) |-> (pmv_q == '0))
      else $error("start state shows a vector");
endmodule

// File: rtl/bsm_tile.sv
module bsm_tile #(
   parameter int SYM_W    = 8,
   parameter int SLICE_W  = 2,
   parameter int SLICE_LO = 0,
   parameter int ST_W     = 8,
   parameter int PM_W     = 16
) (
   input  logic                                     clk,
   input  logic                                     rst,
   input  logic                                     scan_en,
   input  logic                                     sym_valid,
   input  logic [SYM_W-1:0]                         sym_byte,
   input  logic                                     cfg_we,
   input  logic [ST_W-1:0]                          cfg_addr,
   input  logic [bsm_pkg::fan_of(SLICE_W)*ST_W-1:0] cfg_next,
   input  logic [PM_W-1:0]                          cfg_pmv,
   output logic [ST_W-1:0]                          state_o,
   output logic [PM_W-1:0]                          pmv_o
);
   generate
      if (SLICE_W < 1 || SLICE_LO < 0 || SLICE_LO + SLICE_W > SYM_W) begin : g_bad_slice
         $error("slice does not fit in the symbol");
      end
      if (ST_W < 1 || ST_W > 12) begin : g_bad_state
         $error("state width out of range");
      end
      if (PM_W < 1) begin : g_bad_pmv
         $error("vector width must be positive");
      end
   endgenerate

   logic [SLICE_W-1:0] sel;
   logic [ST_W-1:0]    nxt_ptr;
   logic [PM_W-1:0]    nxt_pmv;
   logic               adv;

   assign adv = scan_en & sym_valid;

   bsm_slice #(.SYM_W(SYM_W), .SLICE_W(SLICE_W), .SLICE_LO(SLICE_LO)) u_slice (
      .sym (sym_byte),
      .sel (sel)
   );

   bsm_table #(.ST_W(ST_W), .PM_W(PM_W), .SLICE_W(SLICE_W)) u_table (
      .clk      (clk),
      .rst      (rst),
      .scan_en  (scan_en),
      .wr_req   (cfg_we),
      .wr_addr  (cfg_addr),
      .wr_ptrs  (cfg_next),
      .wr_pmv   (cfg_pmv),
      .rd_state (state_o),
      .rd_sel   (sel),
      .nxt_ptr  (nxt_ptr),
      .nxt_pmv  (nxt_pmv)
   );

   bsm_step #(.ST_W(ST_W), .PM_W(PM_W)) u_step (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .nxt_ptr (nxt_ptr),
      .nxt_pmv (nxt_pmv),
      .state_q (state_o),
      .pmv_q   (pmv_o)
   );
endmodule

// File: tb/sim_bsm_tile.sv
module sim_bsm_tile;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        scan_en = 1'b0;
   logic        sym_valid = 1'b0;
   logic [7:0]  sym_byte = 8'h00;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = 8'h00;
   logic [31:0] cfg_next = 32'h0;
   logic [15:0] cfg_pmv = 16'h0;
   logic [7:0]  state_o;
   logic [15:0] pmv_o;

   int total = 0;
   int bad = 0;

   logic [7:0]  mptr [256][4];
   logic [15:0] mpmv [256];
   logic [7:0]  est = 8'h00;
   logic [15:0] epm = 16'h0;

   always #5 clk = ~clk;

   bsm_tile u0 (
      .clk(clk), .rst(rst), .scan_en(scan_en), .sym_valid(sym_valid),
      .sym_byte(sym_byte), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_next(cfg_next), .cfg_pmv(cfg_pmv), .state_o(state_o), .pmv_o(pmv_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] tptr(input int s, input int k);
      if (s == 15 && k == 3) return 8'd40;
      if (s == 0 && k == 2) return 8'd200;
      if ((s + k) % 5 == 0) return 8'd0;
      return 8'((s * 7 + k * 5 + 3) & 15);
   endfunction

   function automatic logic [15:0] tpmv(input int s);
      if (s == 0) return 16'hFFFF;
      return 16'((s * 16'h9E37) ^ (s << 3));
   endfunction

   task automatic wr(input int a, input logic [7:0] p0, input logic [7:0] p1,
                     input logic [7:0] p2, input logic [7:0] p3,
                     input logic [15:0] pm, input logic scan);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 8'(a); cfg_next = {p3, p2, p1, p0};
      cfg_pmv = pm; scan_en = scan; sym_valid = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0;
      if (!scan) begin
         mptr[a][0] = p0; mptr[a][1] = p1; mptr[a][2] = p2; mptr[a][3] = p3;
         mpmv[a] = pm;
      end
   endtask

   task automatic step(input logic [7:0] b, input logic v, input logic scan, input string tag);
      @(negedge clk);
      sym_byte = b; sym_valid = v; scan_en = scan;
      @(negedge clk);
      sym_valid = 1'b0;
      if (v && scan) begin
         est = mptr[est][b[1:0]];
         epm = (est == 8'd0) ? 16'h0 : mpmv[est];
      end
      chk({tag, " state"}, 32'(state_o), 32'(est));
      chk({tag, " vector"}, 32'(pmv_o), 32'(epm));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int s = 0; s < 256; s++) begin
         mpmv[s] = 16'h0;
         for (int k = 0; k < 4; k++) mptr[s][k] = 8'h0;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk("R1 reset state", 32'(state_o), 32'h0);
      chk("R1 reset vector", 32'(pmv_o), 32'h0);
      // R1 and R9: cleared table sends every slice value to 0
      for (int k = 0; k < 4; k++) step(8'(k), 1'b1, 1'b1, "R9 empty table");

      // R10: load sixteen states with scanning disabled
      for (int s = 0; s < 16; s++)
         wr(s, tptr(s, 0), tptr(s, 1), tptr(s, 2), tptr(s, 3), tpmv(s), 1'b0);

      // R9: 0 --k=2--> 200 (never written), then back to 0
      step(8'h02, 1'b1, 1'b1, "R9 into unwritten");
      step(8'h01, 1'b1, 1'b1, "R9 back to start");
      // R5: entry 0 stores FFFF but shows 0
      step(8'h00, 1'b1, 1'b1, "R5 start vector");
      step(8'h03, 1'b1, 1'b1, "R4 leave start");

      // R2 R3 R4: every byte value once, odd stride permutation
      for (int i = 0; i < 256; i++)
         step(8'((i * 37 + 11) & 255), 1'b1, 1'b1, "R2 R3 R4 sweep");

      // R2: high bits differ, slice equal
      for (int i = 0; i < 8; i++) begin
         step(8'hFC | 8'(i & 3), 1'b1, 1'b1, "R2 high bits set");
         step(8'(i & 3), 1'b1, 1'b1, "R2 high bits clear");
      end

      // R6: valid low holds
      for (int i = 0; i < 6; i++) step(8'(i * 41), 1'b0, 1'b1, "R6 idle");
      // R8: scan disabled holds
      for (int i = 0; i < 6; i++) step(8'(i * 23 + 1), 1'b1, 1'b0, "R8 scan off");

      // R7: write during scan is dropped; rewrite current state's edges
      wr(est, 8'd99, 8'd99, 8'd99, 8'd99, 16'h1234, 1'b1);
      wr(99, 8'd0, 8'd0, 8'd0, 8'd0, 16'hBEEF, 1'b1);
      for (int k = 0; k < 4; k++) step(8'(k), 1'b1, 1'b1, "R7 locked write");

      // R10: write with scan off takes effect on the next transition
      wr(est, 8'd77, 8'd77, 8'd77, 8'd77, 16'hA5A5, 1'b0);
      wr(77, 8'd0, 8'd5, 8'd0, 8'd0, 16'h5A5A, 1'b0);
      step(8'h02, 1'b1, 1'b1, "R10 new edge");
      chk("R10 new target", 32'(state_o), 32'd77);
      chk("R10 new vector", 32'(pmv_o), 32'h5A5A);
      step(8'h01, 1'b1, 1'b1, "R10 second edge");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule